// File: doc/BRIEF.md
# PCI Logical Channel Address Translator

This block turns 32-bit PCI memory addresses into system memory addresses. The address space is cut into 1,024 logical channels of 4 Mbytes each. The ten upper address bits choose a channel, and the low 22 bits are an offset that passes through unchanged. Each channel holds four things: a 4-Mbyte-aligned system base, the one controller allowed to use it, a valid flag, and the direction table it belongs to. Reads and writes each have their own table. The last sixteen channel numbers are reserved and never translate.

Software sets up or clears one entry with a single write to the builder word. Each PCI beat asks for a lookup, and the answer comes back one clock later. The answer is either a translated address or an error code. A small state machine steps the address of a burst. It has two states: IDLE, where every beat carries its own address, and BURST, where a beat without a start mark takes the previous beat's address plus four bytes. The transitions are: IDLE to BURST on a valid beat that is not marked last; BURST to IDLE on a valid last beat; otherwise the state holds. A burst that crosses a 4-Mbyte line carries on in the next channel number, using that channel's own mapping.

Top module: `pci_chan_xlate`

## Requirements
- R1: The channel number is `req_addr[31:22]` (after burst stepping) and the offset is bits 21:0.
- R2: A valid request gives `rsp_valid` high exactly one clock later. A successful response has `rsp_err`=0 and `rsp_addr` = {entry base, unchanged offset}. No request means no response strobe.
- R3: Any beat that decodes to channels 1008–1023 returns `rsp_err`=1 with `rsp_addr`=0.
- R4: One builder write makes a channel usable. The builder word layout is: [9:0] channel, [19:10] system base bits 31:22, [23:20] owner ID, [24] table (0 read, 1 write), [25] clear, [26] valid. The entry is valid when valid=1 and clear=0.
- R5: An access to a valid entry whose `req_ctrl` differs from the owner returns `rsp_err`=3 with `rsp_addr`=0.
- R6: In BURST, a beat with `req_start`=0 uses the previous beat's address plus 4. Crossing a 4-Mbyte line translates through the next channel.
- R7: `req_write` selects the write table when 1 and the read table when 0. An entry built in one table has no effect on the other.
- R8: A builder write with clear=1 invalidates the entry. Access to an invalid entry returns `rsp_err`=2 with `rsp_addr`=0.
- R9: A builder write naming channel 1008–1023 changes no entry and sets `cfg_err`. `cfg_err` stays set until reset.
- R10: A builder write and a lookup of the same entry in the same cycle: the lookup sees the old contents, and the new contents apply from the next cycle.
- R11: When several errors apply, the code chosen is, in order: reserved (1), then not mapped (2), then owner (3).
- R12: After reset, `rsp_valid` and `cfg_err` are 0 and every entry in both tables is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Builder write strobe |
| cfg_data | input | 27 | Builder word (layout in R4) |
| req_valid | input | 1 | Lookup request for one beat |
| req_start | input | 1 | Beat carries a fresh address |
| req_last | input | 1 | Final beat of the burst |
| req_write | input | 1 | Access direction, 1 = write |
| req_ctrl | input | 4 | Requesting controller ID |
| req_addr | input | 32 | PCI address for a start beat |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 2 | 0 ok, 1 reserved, 2 not mapped, 3 owner |
| rsp_addr | output | 32 | Translated system address, 0 on error |
| cfg_err | output | 1 | Sticky reserved-build flag |

## Verification
The stepping assertion relies on one assumption: the requester keeps `req_start` low only on beats that really continue the burst it started. The stimulus always opens a burst with a start beat and ends it with a last beat. The offset and latency properties expect `req_valid` to be a clean single-cycle qualifier with no X after reset, and the bench drives every request input on the falling edge. Random builder words draw channel numbers close to the reserved boundary and owner IDs from a small pool. This keeps matches, mismatches and reserved hits all frequent.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    typedef enum logic [1:0] {
        XL_OK       = 2'd0,
        XL_RSV      = 2'd1,
        XL_UNMAPPED = 2'd2,
        XL_OWNER    = 2'd3
    } xl_err_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } step_state_e;

endpackage

// File: rtl/pcx_table.sv
module pcx_table #(
    parameter int CHAN_W = 10,
    parameter int OWN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_idx,
    input  logic [CHAN_W-1:0] wr_base,
    input  logic [OWN_W-1:0]  wr_owner,
    input  logic              wr_valid,
    input  logic [CHAN_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [CHAN_W-1:0] rd_base,
    output logic [OWN_W-1:0]  rd_owner
);
    localparam int NUM_CHAN = 1 << CHAN_W;

    logic [NUM_CHAN-1:0] vld_q;
    logic [CHAN_W-1:0]   base_mem [NUM_CHAN];
    logic [OWN_W-1:0]    own_mem  [NUM_CHAN];

    // valid bits are the only reset state; contents are qualified by them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            base_mem[wr_idx] <= wr_base;
            own_mem[wr_idx]  <= wr_owner;
        end
    end

    // combinational read: the same-cycle write lands at the edge, so a
    // lookup in that cycle sees the previous contents
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_base  = base_mem[rd_idx];
        rd_owner = own_mem[rd_idx];
    end

    // R8: a clearing write leaves the entry invalid
    p_clear_invalidates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !vld_q[$past(wr_idx)]);

    // R4: a validating write leaves the entry valid
    p_build_validates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/pcx_stepper.sv
module pcx_stepper
    import pcx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_start,
    input  logic              req_last,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [ADDR_W-1:0] beat_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    step_state_e       state_q, state_d;
    logic [ADDR_W-1:0] next_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid && !req_last) state_d = ST_BURST;
            ST_BURST: if (req_valid && req_last)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            next_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) next_q <= beat_addr + STEP;
        end
    end

    // output process: address the current beat is translated with
    always_comb begin
        unique case (state_q)
            ST_IDLE:  beat_addr = req_addr;
            ST_BURST: beat_addr = req_start ? req_addr : next_q;
            default:  beat_addr = req_addr;
        endcase
    end

    // R6: back-to-back continuation beats advance by one beat
    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid) && !$past(req_last) && req_valid && !req_start)
        |-> (beat_addr == $past(beat_addr) + STEP));

endmodule

// File: rtl/pcx_judge.sv
module pcx_judge
    import pcx_pkg::*;
#(
    parameter int OWN_W = 4
) (
    input  logic             is_rsv,
    input  logic             ent_valid,
    input  logic [OWN_W-1:0] ent_owner,
    input  logic [OWN_W-1:0] req_ctrl,
    output xl_err_e          err
);
    // priority: reserved, then not mapped, then owner
    always_comb begin
        if (is_rsv)                      err = XL_RSV;
        else if (!ent_valid)             err = XL_UNMAPPED;
        else if (ent_owner != req_ctrl)  err = XL_OWNER;
        else                             err = XL_OK;
    end

endmodule

// File: rtl/pci_chan_xlate.sv
module pci_chan_xlate
    import pcx_pkg::*;
#(
    parameter int CHAN_W     = 10,
    parameter int OFF_W      = 22,
    parameter int OWN_W      = 4,
    parameter int RSV_COUNT  = 16,
    parameter int BEAT_BYTES = 4,
    parameter int CFG_W      = 2 * CHAN_W + OWN_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_data,
    input  logic                    req_valid,
    input  logic                    req_start,
    input  logic                    req_last,
    input  logic                    req_write,
    input  logic [OWN_W-1:0]        req_ctrl,
    input  logic [CHAN_W+OFF_W-1:0] req_addr,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_err,
    output logic [CHAN_W+OFF_W-1:0] rsp_addr,
    output logic                    cfg_err
);
    localparam int ADDR_W    = CHAN_W + OFF_W;
    localparam int NUM_CHAN  = 1 << CHAN_W;
    localparam int FIRST_RSV = NUM_CHAN - RSV_COUNT;
    localparam logic [CHAN_W-1:0] RSV_IDX = CHAN_W'(FIRST_RSV);
    localparam int F_BASE = CHAN_W;
    localparam int F_OWN  = 2 * CHAN_W;
    localparam int F_SEL  = F_OWN + OWN_W;
    localparam int F_CLR  = F_SEL + 1;
    localparam int F_VLD  = F_CLR + 1;

    // builder word fields
    logic [CHAN_W-1:0] cfg_chan, cfg_base;
    logic [OWN_W-1:0]  cfg_owner;
    logic              cfg_sel, cfg_valid, cfg_rsv;

    always_comb begin
        cfg_chan  = cfg_data[CHAN_W-1:0];
        cfg_base  = cfg_data[F_BASE +: CHAN_W];
        cfg_owner = cfg_data[F_OWN +: OWN_W];
        cfg_sel   = cfg_data[F_SEL];
        cfg_valid = cfg_data[F_VLD] & ~cfg_data[F_CLR];
        cfg_rsv   = (cfg_chan >= RSV_IDX);
    end

    // burst address stepping
    logic [ADDR_W-1:0] beat_addr;

    pcx_stepper #(
        .ADDR_W     (ADDR_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_start (req_start),
        .req_last  (req_last),
        .req_addr  (req_addr),
        .beat_addr (beat_addr)
    );

    logic [CHAN_W-1:0] beat_chan;
    logic [OFF_W-1:0]  beat_off;
    logic              beat_rsv;

    always_comb begin
        beat_chan = beat_addr[ADDR_W-1:OFF_W];
        beat_off  = beat_addr[OFF_W-1:0];
        beat_rsv  = (beat_chan >= RSV_IDX);
    end

    // one table per direction: index 0 read, index 1 write
    logic              t_valid [2];
    logic [CHAN_W-1:0] t_base  [2];
    logic [OWN_W-1:0]  t_owner [2];

    for (genvar d = 0; d < 2; d++) begin : g_tbl
        logic wr_hit;
        assign wr_hit = cfg_we && !cfg_rsv && (cfg_sel == 1'(d));

        pcx_table #(
            .CHAN_W (CHAN_W),
            .OWN_W  (OWN_W)
        ) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit),
            .wr_idx   (cfg_chan),
            .wr_base  (cfg_base),
            .wr_owner (cfg_owner),
            .wr_valid (cfg_valid),
            .rd_idx   (beat_chan),
            .rd_valid (t_valid[d]),
            .rd_base  (t_base[d]),
            .rd_owner (t_owner[d])
        );
    end

    logic              ent_valid;
    logic [CHAN_W-1:0] ent_base;
    logic [OWN_W-1:0]  ent_owner;

    always_comb begin
        ent_valid = t_valid[req_write];
        ent_base  = t_base[req_write];
        ent_owner = t_owner[req_write];
    end

    xl_err_e beat_err;

    pcx_judge #(
        .OWN_W (OWN_W)
    ) u_judge (
        .is_rsv    (beat_rsv),
        .ent_valid (ent_valid),
        .ent_owner (ent_owner),
        .req_ctrl  (req_ctrl),
        .err       (beat_err)
    );

    // response register: one clock after the request
    logic              rsp_valid_q, cfg_err_q;
    xl_err_e           rsp_err_q;
    logic [ADDR_W-1:0] rsp_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= XL_OK;
            rsp_addr_q  <= '0;
            cfg_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            if (req_valid) begin
                rsp_err_q  <= beat_err;
                rsp_addr_q <= (beat_err == XL_OK) ? {ent_base, beat_off} : '0;
            end
            if (cfg_we && cfg_rsv) cfg_err_q <= 1'b1;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_addr  = rsp_addr_q;
    assign cfg_err   = cfg_err_q;

    // R2: response strobe follows request by exactly one clock
    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_resp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2: the offset passes through untouched on success
    p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_err != 2'(XL_OK)) ||
                      (rsp_addr[OFF_W-1:0] == $past(beat_addr[OFF_W-1:0])));
    // R3: reserved channel gives the reserved code and no address
    p_rsv_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && beat_rsv) |=> (rsp_err == 2'(XL_RSV)) && (rsp_addr == '0));
    // R9: reserved build raises the flag and it stays raised
    p_rsv_build_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_rsv) |=> cfg_err);
    p_cfg_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

// File: tb/pci_chan_xlate_test.sv
module pci_chan_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [26:0] cfg_data = '0;
    logic        req_valid = 1'b0, req_start = 1'b0, req_last = 1'b0, req_write = 1'b0;
    logic [3:0]  req_ctrl = '0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, cfg_err;
    logic [1:0]  rsp_err;
    logic [31:0] rsp_addr;

    always #4 clk = ~clk;

    pci_chan_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_start(req_start), .req_last(req_last),
        .req_write(req_write), .req_ctrl(req_ctrl), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .cfg_err(cfg_err)
    );

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    // independent model of the tables and the burst stepper
    logic [9:0]  m_base [2][1024];
    logic [3:0]  m_own  [2][1024];
    bit          m_vld  [2][1024];
    bit          m_burst = 0;
    logic [31:0] m_next = '0;
    bit          m_cfgerr = 0;
    logic [1:0]  x_err;
    logic [31:0] x_addr;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [26:0] word(input int ch, input int base, input int own,
                                         input bit sel, input bit clr, input bit vld);
        return {vld, clr, sel, 4'(own), 10'(base), 10'(ch)};
    endfunction

    function automatic void expect_for(input logic [31:0] a, input bit wr, input logic [3:0] c,
                                       output logic [1:0] e, output logic [31:0] x);
        int ch = int'(a[31:22]);
        x = '0;
        if (ch >= 1008)                e = 2'd1;
        else if (!m_vld[wr][ch])       e = 2'd2;
        else if (m_own[wr][ch] != c)   e = 2'd3;
        else begin e = 2'd0; x = {m_base[wr][ch], a[21:0]}; end
    endfunction

    function automatic void model_cfg(input logic [26:0] w);
        int ch = int'(w[9:0]);
        if (ch >= 1008) m_cfgerr = 1;
        else begin
            m_base[w[24]][ch] = w[19:10];
            m_own[w[24]][ch]  = w[23:20];
            m_vld[w[24]][ch]  = w[26] & ~w[25];
        end
    endfunction

    // drive a beat (at a falling edge) and compute its expected response
    task automatic beat_drive(input bit st, input bit last, input bit wr,
                              input logic [3:0] c, input logic [31:0] a);
        logic [31:0] eff = (!m_burst || st) ? a : m_next;
        m_next = eff + 32'd4;
        m_burst = !last;
        expect_for(eff, wr, c, x_err, x_addr);
        req_valid = 1; req_start = st; req_last = last; req_write = wr;
        req_ctrl = c; req_addr = a;
    endtask

    task automatic beat_check(input string req);
        @(negedge clk);
        req_valid = 0;
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " err"},   32'(rsp_err),   32'(x_err));
        chk({req, " addr"},  rsp_addr,       x_addr);
    endtask

    task automatic beat(input string req, input bit st, input bit last, input bit wr,
                        input logic [3:0] c, input logic [31:0] a);
        beat_drive(st, last, wr, c, a);
        beat_check(req);
    endtask

    task automatic build(input logic [26:0] w);
        cfg_we = 1; cfg_data = w;
        @(negedge clk);
        cfg_we = 0;
        model_cfg(w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 1024; i++) begin
                m_vld[d][i] = 0; m_base[d][i] = '0; m_own[d][i] = '0;
            end
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 rsp_valid at reset", 32'(rsp_valid), 32'd0);
        chk("R12 cfg_err at reset", 32'(cfg_err), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R2 no strobe without request", 32'(rsp_valid), 32'd0);
        beat("R12 unmapped after reset", 1, 1, 0, 4'd3, {10'd5, 22'h000010});

        // R4 R1 R2: one build makes channel 5 usable
        build(word(5, 10'h123, 3, 0, 0, 1));
        beat("R4 R1 R2 translate read ch5", 1, 1, 0, 4'd3, {10'd5, 22'h2ABCD4});
        // R7: write table untouched, then separate entry
        beat("R7 write table still empty", 1, 1, 1, 4'd3, {10'd5, 22'h000100});
        build(word(5, 10'h055, 3, 1, 0, 1));
        beat("R7 write table own base", 1, 1, 1, 4'd3, {10'd5, 22'h000100});
        beat("R7 read table kept", 1, 1, 0, 4'd3, {10'd5, 22'h000100});
        // R5: owner mismatch
        beat("R5 foreign controller", 1, 1, 0, 4'd2, {10'd5, 22'h000040});
        // R3 R11: reserved edges, even with bad owner
        beat("R3 ch1008 refused", 1, 1, 0, 4'd3, {10'd1008, 22'h0});
        beat("R3 R11 ch1023 refused", 1, 1, 1, 4'd9, {10'd1023, 22'h3FFFFC});
        beat("R1 ch1007 usable boundary", 1, 1, 0, 4'd0, {10'd1007, 22'h0});
        // R9: reserved build ignored, sticky flag
        build(word(1010, 10'h3FF, 1, 0, 0, 1));
        chk("R9 cfg_err set", 32'(cfg_err), 32'd1);
        beat("R9 ch1010 still refused", 1, 1, 0, 4'd1, {10'd1010, 22'h8});
        build(word(6, 10'h0AA, 1, 0, 0, 1));
        chk("R9 cfg_err stays", 32'(cfg_err), 32'(m_cfgerr));
        // R8 R11: clear gives not-mapped even for wrong owner
        build(word(6, 10'h0AA, 1, 0, 1, 1));
        beat("R8 R11 cleared entry", 1, 1, 0, 4'd2, {10'd6, 22'h10});
        build(word(6, 10'h0AA, 1, 0, 0, 0));
        beat("R8 valid bit low", 1, 1, 0, 4'd1, {10'd6, 22'h10});
        // R6: burst crossing from channel 7 into channel 8
        build(word(7, 10'h200, 4, 0, 0, 1));
        build(word(8, 10'h011, 4, 0, 0, 1));
        beat("R6 burst beat0", 1, 0, 0, 4'd4, {10'd7, 22'h3FFFF8});
        beat("R6 burst beat1", 0, 0, 0, 4'd4, 32'hDEAD_BEEF);
        beat("R6 burst crosses", 0, 0, 0, 4'd4, 32'h0);
        beat("R6 burst beat3", 0, 1, 0, 4'd4, 32'h0);
        // R10: same-cycle build and lookup see old contents
        cfg_we = 1; cfg_data = word(9, 10'h321, 2, 0, 0, 1);
        beat_drive(1, 1, 0, 4'd2, {10'd9, 22'h44});
        beat_check("R10 lookup sees old (unmapped)");
        cfg_we = 0; model_cfg(word(9, 10'h321, 2, 0, 0, 1));
        beat("R10 new contents next cycle", 1, 1, 0, 4'd2, {10'd9, 22'h44});
        cfg_we = 1; cfg_data = word(9, 10'h0F0, 2, 0, 0, 1);
        beat_drive(1, 1, 0, 4'd2, {10'd9, 22'h48});
        beat_check("R10 overwrite sees old base");
        cfg_we = 0; model_cfg(word(9, 10'h0F0, 2, 0, 0, 1));
        beat("R10 overwrite applied", 1, 1, 0, 4'd2, {10'd9, 22'h48});

        // random mix
        for (int it = 0; it < 600; it++) begin
            int kind = int'($urandom % 4);
            int ch = int'($urandom % 12) + (($urandom % 2) ? 1000 : 0);
            logic [3:0] c = 4'($urandom % 3);
            bit wr = 1'($urandom % 2);
            if (kind == 0) begin
                build(word(ch, int'($urandom % 1024), int'($urandom % 3), 1'($urandom % 2),
                           1'(($urandom % 5) == 0), 1'(($urandom % 6) != 0)));
                chk("R9 random cfg_err", 32'(cfg_err), 32'(m_cfgerr));
            end else if (kind == 1) begin
                beat("R1 R2 R5 random beat", 1, 1, wr, c, {10'(ch), 22'($urandom)});
            end else begin
                int n = int'($urandom % 4) + 2;
                for (int b = 0; b < n; b++)
                    beat("R6 R11 random burst", b == 0, b == n - 1, wr, c,
                         {10'(ch), 22'h3FFFF0 + 22'(4 * ($urandom % 4))});
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule